// File: doc/BRIEF.md
# Indirect Command-Word Register Bridge

This block sits between a host bus and a small bank of 8-bit registers inside a two-wire serial controller. The host sees a single 64-bit command word. To reach an inner register, software writes one word that holds a launch flag, a direction flag, an operation code, a register selector and a data byte. The bridge then runs the inner access, holds the flag high while that access is in progress, and drops the flag when it is done. Software polls the flag. After a read, it takes the fetched byte from the low byte of the same word.

Inner accesses last a fixed number of clock cycles, set by the parameter `ACCESS_CYCLES` (at least 2). Each access issues exactly one read or write strobe to the inner register port, in its first busy cycle. The selector, operation code and write byte stay steady on the inner port for the whole access. The bridge does not interpret the inner register map; the inner controller decodes the selector and the operation code. Selector 3, for example, reaches one register on a write and a different register on a read.

Top module: `indirect_csr_bridge`

## Requirements
- R1: After reset the host word reads all zeros and neither inner strobe is active.
- R2: A host write with bit 63 set, made while bit 63 reads 0, launches an access. Bit 63 then reads 1 for exactly `ACCESS_CYCLES` cycles, beginning the cycle after the write, and then returns to 0.
- R3: Each access produces exactly one inner strobe, in its first busy cycle. The read strobe is used when command bit 56 is 1 and the write strobe when bit 56 is 0. The two strobes are never active together.
- R4: During an access, command bits 34:32 drive `innerSel`, command bits 59:58 drive `innerOp`, and command bits 7:0 drive `innerWrData`. All three stay stable until the access ends.
- R5: When a read access completes, bits 7:0 of the host word hold the `innerRdData` value sampled in the last busy cycle. A write access leaves the written byte in bits 7:0.
- R6: A host write that arrives while bit 63 reads 1 is ignored. It changes no bit of the host word and causes no extra strobe.
- R7: A host write with bit 63 clear starts no access and leaves the host word unchanged.
- R8: Every bit of the host word other than 63, 59:58, 56, 34:32 and 7:0 reads 0, whatever value was written into it.
- R9: An access with operation code 2'b10 and selector 0 reaches the clock high-period register. An access with operation code 2'b11 and selector 1, 2, 3 or 7 reaches the data, control, clock-control/status or soft-reset register. The bridge passes both kinds through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host write strobe for the command word |
| hostWrData | input | 64 | Command word written by the host |
| hostRdData | output | 64 | Current command word, including the busy flag and the returned byte |
| innerWrStb | output | 1 | One-cycle write strobe to the inner register port |
| innerRdStb | output | 1 | One-cycle read strobe to the inner register port |
| innerOp | output | 2 | Operation code presented to the inner port |
| innerSel | output | 3 | Register selector presented to the inner port |
| innerWrData | output | 8 | Byte presented for an inner write |
| innerRdData | input | 8 | Byte returned by the inner register port |

## Verification
The assertions check several properties on every cycle. At most one strobe is active, and only while the busy flag is set. Every rising edge of the busy flag comes with a strobe. The word and the inner selector are frozen for the whole busy window. Undefined bits always read zero. Only the bench scenarios can show the exact length of the busy window and the correct returned byte for each register code, including selector 3 giving a different register on a read than on a write. They also show that a command dropped during a busy window leaves no trace in the inner registers afterwards.

// File: rtl/csr_bridge_pkg.sv
package csr_bridge_pkg;
  localparam int WORD_W    = 64;
  localparam int BYTE_W    = 8;
  localparam int SEL_W     = 3;
  localparam int OP_W      = 2;
  localparam int VALID_POS = 63;
  localparam int RD_POS    = 56;
  localparam int OP_LO     = 58;
  localparam int SEL_LO    = 32;
  localparam logic [WORD_W-1:0] DEFINED_MASK = 64'h8D00_0007_0000_00FF;

  typedef struct packed {
    logic accept;
    logic issue;
    logic finish;
  } bridgeStrobes_t;
endpackage

// File: rtl/bridge_ctrl.sv
module bridge_ctrl
  import csr_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           hostWrEn,
  input  logic           launchBit,
  output bridgeStrobes_t stb
);
  localparam int CW = (ACCESS_CYCLES > 2) ? $clog2(ACCESS_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(ACCESS_CYCLES - 1);

  logic          busyQ;
  logic [CW-1:0] cntQ;

  always_comb begin
    stb.accept = hostWrEn && launchBit && !busyQ;
    stb.issue  = busyQ && (cntQ == CNT_TOP);
    stb.finish = busyQ && (cntQ == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      cntQ  <= '0;
    end else if (stb.accept) begin
      busyQ <= 1'b1;
      cntQ  <= CNT_TOP;
    end else if (stb.finish) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      cntQ <= cntQ - 1'b1;
    end
  end
endmodule

// File: rtl/bridge_dp.sv
module bridge_dp
  import csr_bridge_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStrobes_t    stb,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              innerWrStb,
  output logic              innerRdStb,
  output logic [OP_W-1:0]   innerOp,
  output logic [SEL_W-1:0]  innerSel,
  output logic [BYTE_W-1:0] innerWrData,
  input  logic [BYTE_W-1:0] innerRdData
);
  logic              validQ;
  logic              rdQ;
  logic [OP_W-1:0]   opQ;
  logic [SEL_W-1:0]  selQ;
  logic [BYTE_W-1:0] byteQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= 1'b0;
      rdQ    <= 1'b0;
      opQ    <= '0;
      selQ   <= '0;
      byteQ  <= '0;
    end else if (stb.accept) begin
      validQ <= 1'b1;
      rdQ    <= hostWrData[RD_POS];
      opQ    <= hostWrData[OP_LO +: OP_W];
      selQ   <= hostWrData[SEL_LO +: SEL_W];
      byteQ  <= hostWrData[BYTE_W-1:0];
    end else if (stb.finish) begin
      validQ <= 1'b0;
      if (rdQ) byteQ <= innerRdData;
    end
  end

  always_comb begin
    hostRdData                  = '0;
    hostRdData[VALID_POS]       = validQ;
    hostRdData[RD_POS]          = rdQ;
    hostRdData[OP_LO +: OP_W]   = opQ;
    hostRdData[SEL_LO +: SEL_W] = selQ;
    hostRdData[BYTE_W-1:0]      = byteQ;
  end

  assign innerWrStb  = stb.issue && !rdQ;
  assign innerRdStb  = stb.issue && rdQ;
  assign innerOp     = opQ;
  assign innerSel    = selQ;
  assign innerWrData = byteQ;
endmodule

// File: rtl/indirect_csr_bridge.sv
module indirect_csr_bridge
  import csr_bridge_pkg::*;
#(
  parameter int ACCESS_CYCLES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [WORD_W-1:0] hostWrData,
  output logic [WORD_W-1:0] hostRdData,
  output logic              innerWrStb,
  output logic              innerRdStb,
  output logic [OP_W-1:0]   innerOp,
  output logic [SEL_W-1:0]  innerSel,
  output logic [BYTE_W-1:0] innerWrData,
  input  logic [BYTE_W-1:0] innerRdData
);
  bridgeStrobes_t stb;

  bridge_ctrl #(.ACCESS_CYCLES(ACCESS_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .hostWrEn (hostWrEn),
    .launchBit(hostWrData[VALID_POS]),
    .stb      (stb)
  );

  bridge_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .innerWrStb (innerWrStb),
    .innerRdStb (innerRdStb),
    .innerOp    (innerOp),
    .innerSel   (innerSel),
    .innerWrData(innerWrData),
    .innerRdData(innerRdData)
  );
endmodule

// File: rtl/indirect_csr_bridge_chk.sv
module indirect_csr_bridge_chk
  import csr_bridge_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [WORD_W-1:0] hostRdData,
  input logic              innerWrStb,
  input logic              innerRdStb,
  input logic [OP_W-1:0]   innerOp,
  input logic [SEL_W-1:0]  innerSel
);
  a_r3_single_kind: assert property (@(posedge clk) disable iff (!rstN)
    !(innerWrStb && innerRdStb));

  a_r3_strobe_in_busy: assert property (@(posedge clk) disable iff (!rstN)
    (innerWrStb || innerRdStb) |-> hostRdData[VALID_POS]);

  a_r2_launch_strobes: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostRdData[VALID_POS]) |-> (innerWrStb || innerRdStb));

  a_r6_word_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdData[VALID_POS] && $past(hostRdData[VALID_POS])) |-> $stable(hostRdData));

  a_r4_port_stable: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdData[VALID_POS] && $past(hostRdData[VALID_POS])) |->
      ($stable(innerSel) && $stable(innerOp)));

  a_r8_undefined_zero: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdData & ~DEFINED_MASK) == '0);
endmodule

bind indirect_csr_bridge indirect_csr_bridge_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .hostRdData(hostRdData),
  .innerWrStb(innerWrStb),
  .innerRdStb(innerRdStb),
  .innerOp   (innerOp),
  .innerSel  (innerSel)
);

// File: tb/test_indirect_csr_bridge.sv
module test_indirect_csr_bridge;
  localparam int N = 4;
  localparam logic [63:0] MASK = 64'h8D00_0007_0000_00FF;
  localparam logic [63:0] JUNK = 64'h72F0_A3F8_5A5A_C300;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic hostWrEn = 1'b0;
  logic [63:0] hostWrData = '0;
  logic [63:0] hostRdData;
  logic innerWrStb, innerRdStb;
  logic [1:0] innerOp;
  logic [2:0] innerSel;
  logic [7:0] innerWrData, innerRdData;

  int errors = 0;
  int checks = 0;
  int doneCount = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  indirect_csr_bridge #(.ACCESS_CYCLES(N)) i_indirect_csr_bridge (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .innerWrStb(innerWrStb), .innerRdStb(innerRdStb),
    .innerOp(innerOp), .innerSel(innerSel), .innerWrData(innerWrData),
    .innerRdData(innerRdData)
  );

  // inner register bank model: selector 3 reads status, writes clock control
  logic [7:0] bank [8];
  logic [7:0] clkHigh = 8'h00;
  logic [7:0] clkCtl = 8'h00;
  initial for (int i = 0; i < 8; i++) bank[i] = 8'h00;
  assign innerRdData = (innerOp == 2'b10) ? clkHigh :
                       (innerSel == 3'd3) ? 8'hF8 : bank[innerSel];
  always @(posedge clk) if (innerWrStb) begin
    if (innerOp == 2'b10) clkHigh <= innerWrData;
    else if (innerSel == 3'd3) clkCtl <= innerWrData;
    else bank[innerSel] <= innerWrData;
  end

  // shadow used to compute expected read bytes
  logic [7:0] shBank [8];
  logic [7:0] shClk = 8'h00;
  initial for (int i = 0; i < 8; i++) shBank[i] = 8'h00;

  logic [63:0] expQ [$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: scoreboard pops an expected word at each completion
  logic prevValid = 1'b0;
  int busyCnt = 0;
  int stbCnt = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (hostRdData[63]) begin
        busyCnt++;
        if (innerWrStb || innerRdStb) stbCnt++;
      end else if (prevValid) begin
        logic [63:0] e;
        e = (expQ.size() > 0) ? expQ.pop_front() : 64'hDEAD;
        chk(hostRdData == e, "R5 completed word", hostRdData, e);
        chk(busyCnt == N, "R2 busy length", 64'(busyCnt), 64'(N));
        chk(stbCnt == 1, "R3 strobes per access", 64'(stbCnt), 64'd1);
        busyCnt = 0;
        stbCnt = 0;
        doneCount++;
      end
      prevValid = hostRdData[63];
    end
  end

  // driver: one access, optional ignored second command during busy
  task automatic access(input logic [1:0] op, input bit rd, input logic [2:0] sel,
                        input logic [7:0] data, input bit collide);
    logic [63:0] cmd, exp;
    logic [7:0] rb;
    int k;
    cmd = 64'h8000_0000_0000_0000 | (64'(op) << 58) | (64'(rd) << 56) |
          (64'(sel) << 32) | 64'(data) | (JUNK & ~MASK);
    exp = cmd & MASK & ~64'h8000_0000_0000_0000;
    if (rd) begin
      rb = (op == 2'b10) ? shClk : (sel == 3'd3) ? 8'hF8 : shBank[sel];
      exp[7:0] = rb;
    end else begin
      if (op == 2'b10) shClk = data;
      else if (sel != 3'd3) shBank[sel] = data;
    end
    expQ.push_back(exp);
    k = doneCount;
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = cmd;
    @(negedge clk);
    chk(hostRdData[63] == 1'b1, "R2 flag set", hostRdData, 64'h1);
    chk(rd ? innerRdStb : innerWrStb, "R3 strobe kind", {innerRdStb, innerWrStb}, {rd, !rd});
    chk(innerSel == sel && innerOp == op, "R4 R9 inner selector", {innerOp, innerSel}, {op, sel});
    chk(rd || innerWrData == data, "R4 write byte", innerWrData, data);
    chk((hostRdData & ~MASK) == 0, "R8 undefined bits", hostRdData & ~MASK, 64'h0);
    if (collide) begin
      hostWrData = 64'h8000_0007_0000_0033 | (64'(2'b11) << 58);
    end else begin
      hostWrEn = 1'b0;
    end
    @(negedge clk);
    hostWrEn = 1'b0;
    while (doneCount == k) @(negedge clk);
  endtask

  initial begin
    logic [63:0] snap;
    repeat (3) @(negedge clk);
    chk(hostRdData == 0 && !innerWrStb && !innerRdStb, "R1 reset state", hostRdData, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk(hostRdData == 0, "R1 after release", hostRdData, 64'h0);

    access(2'b11, 1'b0, 3'd1, 8'hA5, 1'b0);  // R9 data register write
    access(2'b11, 1'b1, 3'd1, 8'h00, 1'b0);  // R5 read back
    access(2'b11, 1'b0, 3'd2, 8'h44, 1'b0);  // control write
    access(2'b11, 1'b1, 3'd2, 8'hFF, 1'b0);
    access(2'b11, 1'b0, 3'd3, 8'h13, 1'b0);  // clock control write
    chk(clkCtl == 8'h13, "R9 clock-control write", clkCtl, 8'h13);
    access(2'b11, 1'b1, 3'd3, 8'h00, 1'b0);  // status read gives F8
    access(2'b10, 1'b0, 3'd0, 8'h1C, 1'b0);  // clock high period
    access(2'b10, 1'b1, 3'd0, 8'h00, 1'b0);
    access(2'b11, 1'b0, 3'd7, 8'h00, 1'b0);  // soft reset selector

    // R6: command in busy window dropped; selector 7 stays 00
    access(2'b11, 1'b0, 3'd5, 8'h69, 1'b1);
    access(2'b11, 1'b1, 3'd7, 8'h00, 1'b0);
    chk(bank[7] == 8'h00, "R6 ignored write left no trace", bank[7], 8'h00);

    // R7: write without launch flag
    snap = hostRdData;
    @(negedge clk);
    hostWrEn = 1'b1;
    hostWrData = 64'h0D00_0002_0000_0077;
    @(negedge clk);
    hostWrEn = 1'b0;
    chk(hostRdData == snap && !innerWrStb && !innerRdStb, "R7 no launch", hostRdData, snap);
    @(negedge clk);
    chk(hostRdData == snap, "R7 word unchanged", hostRdData, snap);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule